// File: doc/BRIEF.md
# Converter Ready/Data Serial Sequencer

This block is the digital back end of a delta-sigma converter. Once per conversion period it takes a wide signed result from the filter, clips it to 24 bits, and presents it on a single output pin. That pin does two jobs. A low level tells the host that a new result is waiting. After that, each rising edge of the host's serial clock moves the pin to the next result bit.

The host controls the block with the serial clock alone. The number of pulses and the level at which the clock is held select readout, line release, self-calibration, standby and wakeup. Three select pins choose the channel, the buffer and the temperature input. Any change on one of them restarts the filter, and the pin stays high until settled data exists.

The result bus has no handshake. The block samples it at the clock edge that makes a result ready. There is no back-pressure: a result the host has not read is replaced by the next one. Every time constant is a parameter counted in converter clock cycles.

Top module: `cnv_seq_top`

## Requirements
- R1: `dout` is high during reset. The first result is ready, shown by `dout` going low, `SETTLE_CYC` clock edges after reset is released. Later results follow every `CONV_CYC` edges.
- R2: The first rising edge of `sclk` after a result is ready drives `dout` to result bit 23. Each later rising edge drives the next lower bit, down to bit 0 on the 24th edge.
- R3: After the 24th rising edge, `dout` holds bit 0 until the update window. The 25th rising edge forces `dout` high at once.
- R4: The update window is the last `UPD_CYC` cycles before each result is ready. During the window `dout` is high, and `sclk` rising edges are ignored: no bit is shifted and no edge is counted.
- R5: If a result is not read, the next result replaces it. A later read returns the newest result.
- R6: A raw result above 8388607 reads as 7FFFFFh. A raw result below -8388608 reads as 800000h. Values in between read as their low 24 bits in two's complement.
- R7: The select pins `sel_chan`, `sel_buf` and `sel_temp` are compared with their values at the previous clock edge (all low after reset). A change on any of them drives `dout` high at the next edge and restarts conversion. The next result is ready `SETTLE_CYC` edges after that edge.
- R8: The falling edge of the 26th `sclk` pulse after a result is ready starts calibration, and `dout` is high. A result is ready `CAL_CYC` edges after the block acts on that fall. Results then follow every `CONV_CYC` edges.
- R9: If `sclk` stays high for `STBY_CYC` consecutive cycles during normal conversion, the block enters standby. In standby `dout` stays high and no result becomes ready.
- R10: A low `sclk` ends standby. A result is ready `WAKE_CYC` edges after the block acts on the low level.
- R11: If the high level that leads to standby was the 26th rising edge, wakeup runs calibration first. The result is then ready `WAKECAL_CYC` edges after wakeup, and it is valid.
- R12: `sclk` passes through a two-flop synchronizer. A level or edge on the pin takes effect at the third rising clock edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock, asynchronous |
| sel_chan | input | 1 | Input channel select |
| sel_buf | input | 1 | Input buffer enable |
| sel_temp | input | 1 | Temperature input select |
| raw_result | input | RAW_W | Signed filter result, sampled when a result becomes ready |
| dout | output | 1 | Low for ready, then serial data MSB first |

## Verification
The assertions assume three things about the inputs:
- `sclk` holds each level for at least three converter clocks, so the synchronizer never drops a pulse.
- The select pins change only in step with `clk`.
- `raw_result` is stable at the edge where a result becomes ready.

The stimulus holds every `sclk` level for four clocks and changes pins only at falling clock edges. Reads, calibration pulses and standby holds all begin right after a ready indication, so they end before the update window. The one exception is the edge placed inside the window on purpose.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

  typedef enum logic [1:0] {
    M_CONV  = 2'd0,
    M_CAL   = 2'd1,
    M_SLEEP = 2'd2
  } seq_mode_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cnv_sclk_sync.sv
module cnv_sclk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  // R12: an edge is reported for one cycle only
  a_r12_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/cnv_out_shift.sv
module cnv_out_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         force_hi,
  input  logic         shift,
  output logic         dout,
  output logic         msb
);

  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      dout <= 1'b1;
    end else if (load) begin
      sh   <= ld_data;
      dout <= 1'b0;
    end else if (force_hi) begin
      dout <= 1'b1;
    end else if (shift) begin
      dout <= sh[W-1];
      sh   <= {sh[W-2:0], 1'b0};
    end
  end

  assign msb = sh[W-1];

endmodule

// File: rtl/cnv_seq_top.sv
module cnv_seq_top
  import cnv_seq_pkg::*;
#(
  parameter int OUT_W       = 24,
  parameter int RAW_W       = 26,
  parameter int CONV_CYC    = 16640,
  parameter int UPD_CYC     = 96,
  parameter int SETTLE_CYC  = 52400,
  parameter int CAL_CYC     = 155000,
  parameter int WAKE_CYC    = 55800,
  parameter int WAKECAL_CYC = 158500,
  parameter int STBY_CYC    = 16560
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sel_chan,
  input  logic             sel_buf,
  input  logic             sel_temp,
  input  logic [RAW_W-1:0] raw_result,
  output logic             dout
);

  localparam int TMAX = max_of(max_of(max_of(CONV_CYC, SETTLE_CYC),
                                      max_of(CAL_CYC, WAKE_CYC)), WAKECAL_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam int HW = $clog2(STBY_CYC + 1);
  localparam int PW = $clog2(OUT_W + 3);
  localparam logic [PW-1:0] P_LAST = PW'(OUT_W);
  localparam logic [PW-1:0] P_ARM  = PW'(OUT_W + 1);
  localparam logic [PW-1:0] P_SAT  = PW'(OUT_W + 2);
  localparam logic [TW-1:0] T_WIN  = TW'(UPD_CYC + 1);
  localparam logic [TW-1:0] T_ONE  = TW'(1);
  localparam logic [HW-1:0] H_LAST = HW'(STBY_CYC - 1);
  localparam logic [HW-1:0] H_SAT  = HW'(STBY_CYC);

  // synchronized serial clock
  logic s_lvl, s_rise, s_fall;

  cnv_sclk_sync i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (sclk),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  // result clipping
  logic [OUT_W-1:0] clipped;

  generate
    if (RAW_W > OUT_W) begin : g_clip
      logic [RAW_W-OUT_W:0] hi_bits;
      logic                 ovf;
      assign hi_bits = raw_result[RAW_W-1:OUT_W-1];
      assign ovf     = !((&hi_bits) || !(|hi_bits));
      assign clipped = !ovf ? raw_result[OUT_W-1:0] :
                       (raw_result[RAW_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                            : {1'b0, {(OUT_W-1){1'b1}}});
    end else begin : g_pass
      assign clipped = raw_result;
    end
  endgenerate

  // sequencer state
  seq_mode_e       mode;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   pcnt;
  logic [HW-1:0]   hi_cnt;
  logic            avail, armed;
  logic [2:0]      sel_q, sel_now;

  logic sel_chg, asleep, do_wake, do_restart, do_cal, do_sleep, normal;
  logic ready_evt, win_start, take_edge, shift_en, tail_hi, force_hi;
  logic sh_msb;

  always_comb begin
    sel_now    = {sel_chan, sel_buf, sel_temp};
    sel_chg    = (sel_now != sel_q);
    asleep     = (mode == M_SLEEP);
    do_wake    = asleep && !s_lvl;
    do_restart = !asleep && sel_chg;
    do_cal     = !asleep && !sel_chg && s_fall && armed;
    do_sleep   = !asleep && !sel_chg && !do_cal && (mode == M_CONV) &&
                 s_lvl && (hi_cnt == H_LAST);
    normal     = !asleep && !sel_chg && !do_cal && !do_sleep;
    ready_evt  = normal && (tmr == T_ONE);
    win_start  = normal && (tmr == T_WIN);
    take_edge  = normal && s_rise && avail && !win_start;
    shift_en   = take_edge && (pcnt < P_LAST);
    tail_hi    = take_edge && (pcnt >= P_LAST);
    force_hi   = do_restart || do_cal || do_sleep || win_start || tail_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_CONV;
      tmr    <= TW'(SETTLE_CYC);
      pcnt   <= '0;
      hi_cnt <= '0;
      avail  <= 1'b0;
      armed  <= 1'b0;
      sel_q  <= '0;
    end else begin
      sel_q <= sel_now;
      if (!s_lvl) hi_cnt <= '0;
      else if (hi_cnt != H_SAT) hi_cnt <= hi_cnt + 1'b1;

      if (do_wake) begin
        mode  <= armed ? M_CAL : M_CONV;
        tmr   <= armed ? TW'(WAKECAL_CYC) : TW'(WAKE_CYC);
        armed <= 1'b0;
        pcnt  <= '0;
      end else if (do_restart) begin
        mode  <= M_CONV;
        tmr   <= TW'(SETTLE_CYC);
        avail <= 1'b0;
        armed <= 1'b0;
        pcnt  <= '0;
      end else if (do_cal) begin
        mode  <= M_CAL;
        tmr   <= TW'(CAL_CYC);
        avail <= 1'b0;
        armed <= 1'b0;
      end else if (do_sleep) begin
        mode  <= M_SLEEP;
        avail <= 1'b0;
      end else if (ready_evt) begin
        mode  <= M_CONV;
        tmr   <= TW'(CONV_CYC);
        avail <= 1'b1;
        pcnt  <= '0;
      end else begin
        tmr <= tmr - 1'b1;
        if (win_start) avail <= 1'b0;
        if (take_edge) begin
          if (pcnt != P_SAT) pcnt <= pcnt + 1'b1;
          if (pcnt == P_ARM) armed <= 1'b1;
        end
      end
    end
  end

  cnv_out_shift #(.W(OUT_W)) i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ready_evt),
    .ld_data (clipped),
    .force_hi(force_hi),
    .shift   (shift_en),
    .dout    (dout),
    .msb     (sh_msb)
  );

  // R1: a ready event pulls the line low
  a_r1_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    ready_evt |=> !dout);

  // R2: an accepted edge presents the current top bit
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (dout == $past(sh_msb)));

  // R3: edges past the last bit release the line
  a_r3_tail_release: assert property (@(posedge clk) disable iff (!rst_n)
    tail_hi |=> dout);

  // R4: the line does not move inside the update window
  a_r4_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_SLEEP && tmr <= TW'(UPD_CYC) && tmr > T_ONE) |=> $stable(dout));

  // R7: a select change holds the line high
  a_r7_select_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> dout);

  // R9: standby keeps the line high
  a_r9_sleep_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP) |-> dout);

  // R10, R11: wakeup loads one of the two wake delays
  a_r10_wake_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode == M_SLEEP) |-> (tmr == TW'(WAKE_CYC) || tmr == TW'(WAKECAL_CYC)));

endmodule

// File: tb/test_cnv_seq_top.sv
`timescale 1ns/1ps
module test_cnv_seq_top;

  localparam int CONV    = 600;
  localparam int UPD     = 8;
  localparam int SETTLE  = 200;
  localparam int CAL     = 700;
  localparam int WAKE    = 250;
  localparam int WAKECAL = 720;
  localparam int STBY    = 300;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, sclk, sel_chan, sel_buf, sel_temp, dout;
  logic [25:0] raw;
  int cyc = 0;
  int nchk = 0, nerr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  cnv_seq_top #(
    .OUT_W(24), .RAW_W(26), .CONV_CYC(CONV), .UPD_CYC(UPD),
    .SETTLE_CYC(SETTLE), .CAL_CYC(CAL), .WAKE_CYC(WAKE),
    .WAKECAL_CYC(WAKECAL), .STBY_CYC(STBY)
  ) i_cnv_seq_top (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_chan(sel_chan),
    .sel_buf(sel_buf), .sel_temp(sel_temp), .raw_result(raw), .dout(dout)
  );

  function automatic logic [23:0] exp_code(input int v);
    if (v > 8388607)  return 24'h7FFFFF;
    if (v < -8388608) return 24'h800000;
    return v[23:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wait_ready(output int t);
    bit seen;
    seen = dout;
    t = -1;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (!dout && seen) begin
        t = cyc;
        break;
      end
      if (dout) seen = 1'b1;
    end
    if (t < 0) chk(1'b0, "ready timeout", 0, 1);
  endtask

  task automatic pulse_read(input int n, output logic [23:0] w, output bit tail);
    w = '0;
    tail = 1'b1;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      if (i < 24) w = {w[22:0], dout};
      else tail = tail & dout;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=end", cyc);
    finish_run();
  end

  initial begin
    int t0, t1, t2, tc, tw, lows, pin;
    logic [23:0] w;
    bit th;
    sclk = 0; sel_chan = 0; sel_buf = 0; sel_temp = 0; rst_n = 0;
    raw = 26'(1193046);
    repeat (5) @(negedge clk);
    chk(dout == 1'b1, "R1 reset level", dout, 1);

    rst_n = 1; t0 = cyc;
    wait_ready(t1);
    chk(t1 - t0 == SETTLE, "R1 first result after settle", t1 - t0, SETTLE);
    pulse_read(25, w, th);
    chk(w == exp_code(1193046), "R2 msb-first word", w, exp_code(1193046));
    chk(th, "R3 25th edge releases line", th, 1);

    // R6 negative clip, R3 hold of a 0 LSB
    raw = 26'(-8388615);
    wait_ready(t2);
    chk(t2 - t1 == CONV, "R1 conversion period", t2 - t1, CONV);
    pulse_read(24, w, th);
    chk(w == 24'h800000, "R6 negative clip", w, 24'h800000);
    lows = 0;
    repeat (20) begin @(negedge clk); if (!dout) lows++; end
    chk(lows == 20, "R3 holds last bit low", lows, 20);

    // R6 positive clip, R3 hold of a 1 LSB
    raw = 26'(8388700);
    t1 = t2;
    wait_ready(t2);
    chk(t2 - t1 == CONV, "R1 conversion period", t2 - t1, CONV);
    pulse_read(24, w, th);
    chk(w == 24'h7FFFFF, "R6 positive clip", w, 24'h7FFFFF);
    lows = 0;
    repeat (20) begin @(negedge clk); if (!dout) lows++; end
    chk(lows == 0, "R3 holds last bit high", lows, 0);

    // R5 unread result replaced
    raw = 26'(-5);
    t1 = t2;
    wait_ready(t2);
    chk(t2 - t1 == CONV, "R1 period after hold", t2 - t1, CONV);
    raw = 26'(700000);
    t1 = t2;
    wait_ready(t2);
    chk(t2 - t1 == CONV, "R5 next result on time", t2 - t1, CONV);
    pulse_read(24, w, th);
    chk(w == exp_code(700000), "R5 newest result read", w, exp_code(700000));

    // R4 edge inside update window is ignored
    raw = 26'(986895);
    wait_ready(t1);
    raw = 26'(-5);
    while (cyc < t1 + CONV - UPD) @(negedge clk);
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    chk(dout == 1'b1, "R4 window edge ignored", dout, 1);
    sclk = 1'b0;
    wait_ready(t2);
    chk(t2 - t1 == CONV, "R4 period kept", t2 - t1, CONV);
    pulse_read(25, w, th);
    chk(w == exp_code(-5), "R4 R6 read after window edge", w, exp_code(-5));
    chk(th, "R3 release after in-range read", th, 1);

    // R8 calibration on 26th pulse fall
    raw = 26'(3947580);
    wait_ready(t1);
    pulse_read(25, w, th);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0; tc = cyc;
    wait_ready(t2);
    chk(t2 - tc == CAL + 3, "R8 R12 calibration delay", t2 - tc, CAL + 3);
    pulse_read(24, w, th);
    chk(w == exp_code(3947580), "R8 result after calibration", w, exp_code(3947580));
    t1 = t2;
    wait_ready(t2);
    chk(t2 - t1 == CONV, "R8 period resumes", t2 - t1, CONV);

    // R7 each select pin restarts the filter
    for (int p = 0; p < 3; p++) begin
      pin = p;
      if (pin == 0) sel_chan = ~sel_chan;
      else if (pin == 1) sel_buf = ~sel_buf;
      else sel_temp = ~sel_temp;
      tc = cyc;
      @(negedge clk);
      chk(dout == 1'b1, "R7 line high after select change", dout, 1);
      wait_ready(t2);
      chk(t2 - tc == SETTLE + 1, "R7 settle after select change", t2 - tc, SETTLE + 1);
    end

    // R9 standby, R10 plain wakeup
    raw = 26'(2763306);
    sclk = 1'b1;
    repeat (STBY + 10) @(negedge clk);
    chk(dout == 1'b1, "R9 standby line high", dout, 1);
    lows = 0;
    repeat (2 * CONV) begin @(negedge clk); if (!dout) lows++; end
    chk(lows == 0, "R9 no result while in standby", lows, 0);
    sclk = 1'b0; tw = cyc;
    wait_ready(t2);
    chk(t2 - tw == WAKE + 3, "R10 R12 wakeup delay", t2 - tw, WAKE + 3);
    pulse_read(25, w, th);
    chk(w == exp_code(2763306), "R10 result after wakeup", w, exp_code(2763306));

    // R11 standby entered on the 26th edge calibrates on wakeup
    raw = 26'(-1000000);
    wait_ready(t1);
    pulse_read(25, w, th);
    chk(w == exp_code(-1000000), "R2 negative in-range word", w, exp_code(-1000000));
    sclk = 1'b1;
    repeat (STBY + 10) @(negedge clk);
    chk(dout == 1'b1, "R11 standby after 25 pulses", dout, 1);
    sclk = 1'b0; tw = cyc;
    wait_ready(t2);
    chk(t2 - tw == WAKECAL + 3, "R11 wakeup with calibration", t2 - tw, WAKECAL + 3);
    pulse_read(24, w, th);
    chk(w == exp_code(-1000000), "R11 result after calibrated wakeup", w, exp_code(-1000000));

    finish_run();
  end

endmodule